// File: doc/BRIEF.md
# Two-Stack Thread Scheduler

This block picks which software thread runs on each step of a single-core machine that time-slices several threads. Thread IDs sit in two hardware LIFO stacks, left and right. A direction bit selects which stack holds the running thread: the top of the right stack when the bit is set, the top of the left stack when it is clear. To switch threads, the running one is moved from its stack onto the other. When the stack in use runs dry, the direction turns around. The result is a back-and-forth visiting order.

Each step the host presents one command: plain step, yield, futex wait, futex wake, exit or spawn. Before the command is acted on, the block gives several scheduling duties priority: an empty stack, a wakeup scan in progress, removing an exited thread, a thread that is waiting on a futex, and a forced switch when the running thread has used its whole quantum.

A side table keeps each thread's futex address, value, timeout step and exited mark. The scheduler shows the address and value of the running thread, so outside logic can compare them against memory and return the result on `mem_differs`.

Top module: `thread_sched`

## Requirements
- R1: After reset both stacks are empty, `active_valid` is 0, `dir_right` is 1, `wake_busy` is 0 and both error flags are 0.
- R2: A step with op 5 (spawn) pushes `spawn_id` onto the stack in use, so that thread becomes the running one. Its futex address is set to all-ones, its value to 0, its timeout to 0 and its exited mark is cleared. Op codes: 0 step, 1 yield, 2 wait, 3 wake, 4 exit, 5 spawn.
- R3: A yield (op 1) pops the running thread and pushes it onto the other stack. If the stack in use is then empty, `dir_right` flips. With threads 0..3 spawned as 3,2,1,0, successive yields give 1,2,3,3,2,1,0,0.
- R4: Each executed instruction step adds one to a switch counter, and any thread switch clears it. A step taken when the counter equals QUANTUM forces a switch and ignores the op on that step.
- R5: A wait (op 2) stores `op_addr`, `op_val` and `op_tmo` for the running thread. These values show on `act_futex_addr` and `act_futex_val`, and the thread stays active for that step.
- R6: On a step where the running thread is waiting (futex address not all-ones), the thread is woken if `cur_step` > timeout or if `mem_differs` is 1. Waking sets the address to all-ones and the value to 0, and the thread stays active. Otherwise the thread is switched out. A `cur_step` equal to the timeout does not wake it.
- R7: A wake (op 3) loads the wakeup register with `op_addr`, which raises `wake_busy`, and switches out the running thread. After that the direction becomes left when the left stack is non-empty.
- R8: On each step while `wake_busy` is 1, a running thread whose futex address equals the wakeup address ends the scan and stays active. A thread that does not match is switched out, and the scan also ends if the right stack is then empty. No thread's futex fields change during the scan.
- R9: An exit (op 4) marks the running thread. On its next step that thread is popped and discarded without being pushed anywhere, and the direction flips if its stack is now empty.
- R10: A non-spawn step taken with both stacks empty sets `err_empty`, which stays set until reset.
- R11: A push onto a full stack (depth NTHR) is dropped and sets `err_overflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | One scheduler step this cycle |
| op | input | 3 | Command code for the step |
| op_addr | input | ADDR_W | Futex address for wait or wake |
| op_val | input | DATA_W | Futex value for wait |
| op_tmo | input | STEP_W | Timeout step for wait |
| spawn_id | input | ID_W | Thread ID for spawn |
| cur_step | input | STEP_W | Incremented global step number |
| mem_differs | input | 1 | Memory at the running thread's futex address differs from its saved value |
| active_id | output | ID_W | Running thread ID |
| active_valid | output | 1 | A running thread exists |
| act_futex_addr | output | ADDR_W | Futex address of the running thread |
| act_futex_val | output | DATA_W | Futex value of the running thread |
| wake_busy | output | 1 | Wakeup scan in progress |
| dir_right | output | 1 | Direction bit, 1 = right stack in use |
| err_empty | output | 1 | Sticky: step with no threads |
| err_overflow | output | 1 | Sticky: push onto a full stack |

## Verification
The hardest case to reach is a wakeup scan that runs out of threads. The wake has to be issued when the left stack gets its first entry from the preemption itself. The scan must then pass the same thread twice across a direction flip, and it ends only when the right stack empties. The bench arranges this with two threads: the wake is issued from thread 0 in right-direction state, and the active ID and busy flag are then followed step by step. A second scan checks the matching path. In that scan one thread is first parked on the wake address through a wait, followed by a step that cannot wake it, and the scan has to move through one non-matching thread before it reaches the parked one.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_YIELD = 3'd1,
    OP_WAIT  = 3'd2,
    OP_WAKE  = 3'd3,
    OP_EXIT  = 3'd4,
    OP_SPAWN = 3'd5
  } sched_op_e;
endpackage

// File: rtl/tsched_lifo.sv
module tsched_lifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic [CW-1:0] cnt,
  output logic          full
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n;

  assign full = (cnt_q == CW'(DEPTH));
  assign cnt  = cnt_q;

  always_comb begin
    cnt_n = cnt_q;
    if (push && !pop)      cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push && ((!pop && cnt_q == CW'(i)) || (pop && cnt_q == CW'(i + 1)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[i] <= '0;
      else if (wr_en) slot_q[i] <= din;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CW'(i + 1)) top = slot_q[i];
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q != CW'(DEPTH))); // R11
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/tsched_futex_tbl.sv
module tsched_futex_tbl #(
  parameter int NTHR   = 4,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int STEP_W = 64,
  localparam int IW    = $clog2(NTHR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic              exit_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [DATA_W-1:0] set_val,
  input  logic [STEP_W-1:0] set_tmo,
  input  logic [IW-1:0]     rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_val,
  output logic [STEP_W-1:0] rd_tmo,
  output logic              rd_exit
);
  logic [ADDR_W-1:0] addr_q [NTHR];
  logic [DATA_W-1:0] val_q  [NTHR];
  logic [STEP_W-1:0] tmo_q  [NTHR];
  logic              exit_q [NTHR];

  for (genvar i = 0; i < NTHR; i++) begin : g_ent
    logic hit;
    assign hit = (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[i] <= '1;
        val_q[i]  <= '0;
        tmo_q[i]  <= '0;
        exit_q[i] <= 1'b0;
      end else if (hit && set_en) begin
        addr_q[i] <= set_addr;
        val_q[i]  <= set_val;
        tmo_q[i]  <= set_tmo;
      end else if (hit && clr_en) begin
        addr_q[i] <= '1;
        val_q[i]  <= '0;
        tmo_q[i]  <= '0;
        exit_q[i] <= 1'b0;
      end else if (hit && exit_en) begin
        exit_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_addr = '1;
    rd_val  = '0;
    rd_tmo  = '0;
    rd_exit = 1'b0;
    for (int i = 0; i < NTHR; i++)
      if (rd_idx == IW'(i)) begin
        rd_addr = addr_q[i];
        rd_val  = val_q[i];
        rd_tmo  = tmo_q[i];
        rd_exit = exit_q[i];
      end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_en, clr_en, exit_en}) <= 1); // R5
endmodule

// File: rtl/thread_sched.sv
module thread_sched
  import tsched_pkg::*;
#(
  parameter int NTHR    = 4,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 32,
  parameter int STEP_W  = 64,
  parameter int QUANTUM = 100000,
  localparam int ID_W   = $clog2(NTHR),
  localparam int CW     = $clog2(NTHR + 1),
  localparam int CTX_W  = $clog2(QUANTUM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_val,
  input  logic [STEP_W-1:0] op_tmo,
  input  logic [ID_W-1:0]   spawn_id,
  input  logic [STEP_W-1:0] cur_step,
  input  logic              mem_differs,
  output logic [ID_W-1:0]   active_id,
  output logic              active_valid,
  output logic [ADDR_W-1:0] act_futex_addr,
  output logic [DATA_W-1:0] act_futex_val,
  output logic              wake_busy,
  output logic              dir_right,
  output logic              err_empty,
  output logic              err_overflow
);
  localparam logic [CTX_W-1:0]  QMAX = CTX_W'(QUANTUM);
  localparam logic [ADDR_W-1:0] ONES = '1;

  logic              dir_q, dir_n;
  logic [ADDR_W-1:0] wake_q, wake_n;
  logic [CTX_W-1:0]  ctx_q, ctx_n;
  logic              eemp_q, eemp_n, eovf_q, eovf_n;

  logic            push [2];
  logic            pop  [2];
  logic [ID_W-1:0] pdat [2];
  logic [ID_W-1:0] top  [2];
  logic [CW-1:0]   cnt  [2];
  logic            full [2];

  logic              t_set, t_clr, t_ex;
  logic [ID_W-1:0]   t_idx;
  logic [STEP_W-1:0] act_tmo;
  logic              act_exit;
  logic              busy, preempt, discard, wake_go;
  sched_op_e         opc;

  // index 0 = left stack, index 1 = right stack
  for (genvar s = 0; s < 2; s++) begin : g_stk
    tsched_lifo #(.DEPTH(NTHR), .W(ID_W)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(push[s]), .pop(pop[s]), .din(pdat[s]),
      .top(top[s]), .cnt(cnt[s]), .full(full[s]));
  end

  tsched_futex_tbl #(.NTHR(NTHR), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .set_en(t_set), .clr_en(t_clr), .exit_en(t_ex),
    .wr_idx(t_idx), .set_addr(op_addr), .set_val(op_val), .set_tmo(op_tmo),
    .rd_idx(active_id), .rd_addr(act_futex_addr), .rd_val(act_futex_val),
    .rd_tmo(act_tmo), .rd_exit(act_exit));

  assign opc          = sched_op_e'(op);
  assign active_id    = top[dir_q];
  assign active_valid = (cnt[dir_q] != '0);
  assign busy         = (wake_q != ONES);
  assign wake_busy    = busy;
  assign dir_right    = dir_q;
  assign err_empty    = eemp_q;
  assign err_overflow = eovf_q;

  always_comb begin
    push[0] = 1'b0; push[1] = 1'b0;
    pop[0]  = 1'b0; pop[1]  = 1'b0;
    pdat[0] = '0;   pdat[1] = '0;
    dir_n = dir_q; wake_n = wake_q; ctx_n = ctx_q;
    eemp_n = eemp_q; eovf_n = eovf_q;
    t_set = 1'b0; t_clr = 1'b0; t_ex = 1'b0; t_idx = active_id;
    preempt = 1'b0; discard = 1'b0; wake_go = 1'b0;
    if (step_en) begin
      if (opc == OP_SPAWN) begin
        t_idx = spawn_id;
        if (full[dir_q]) eovf_n = 1'b1;
        else begin
          push[dir_q] = 1'b1;
          pdat[dir_q] = spawn_id;
          t_clr       = 1'b1;
        end
      end else if (cnt[dir_q] == '0) begin
        if (cnt[~dir_q] == '0) eemp_n = 1'b1;
        else                   dir_n  = ~dir_q;
      end else if (busy) begin
        if (act_futex_addr == wake_q) wake_n = ONES;
        else begin
          preempt = 1'b1;
          if (dir_q && cnt[1] == CW'(1)) wake_n = ONES;
        end
      end else if (act_exit) begin
        discard = 1'b1;
      end else if (act_futex_addr != ONES) begin
        if (cur_step > act_tmo || mem_differs) t_clr   = 1'b1;
        else                                   preempt = 1'b1;
      end else if (ctx_q >= QMAX) begin
        preempt = 1'b1;
      end else begin
        ctx_n = ctx_q + 1'b1;
        unique case (opc)
          OP_YIELD: preempt = 1'b1;
          OP_WAIT:  t_set   = 1'b1;
          OP_WAKE:  begin preempt = 1'b1; wake_go = 1'b1; wake_n = op_addr; end
          OP_EXIT:  t_ex    = 1'b1;
          default:  ;
        endcase
      end
      if (preempt || discard) begin
        pop[dir_q] = 1'b1;
        ctx_n      = '0;
        if (cnt[dir_q] == CW'(1)) dir_n = ~dir_q;
      end
      if (preempt) begin
        if (full[~dir_q]) eovf_n = 1'b1;
        else begin
          push[~dir_q] = 1'b1;
          pdat[~dir_q] = active_id;
        end
      end
      if (wake_go) dir_n = (dir_q || cnt[0] > CW'(1)) ? 1'b0 : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b1;
      wake_q <= ONES;
      ctx_q  <= '0;
      eemp_q <= 1'b0;
      eovf_q <= 1'b0;
    end else begin
      dir_q  <= dir_n;
      wake_q <= wake_n;
      ctx_q  <= ctx_n;
      eemp_q <= eemp_n;
      eovf_q <= eovf_n;
    end
  end

  AST_ACTIVE_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] != '0 || cnt[1] != '0) |-> (cnt[dir_q] != '0)); // R3
  AST_CTX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_q <= QMAX); // R4
  AST_SCAN_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && busy && opc != OP_SPAWN) |-> !(t_set || t_clr || t_ex)); // R8
  AST_EMPTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    eemp_q |=> eemp_q); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    eovf_q |=> eovf_q); // R11
endmodule

// File: tb/thread_sched_tb.sv
module thread_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 4;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_en;
  logic [2:0]    op;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_val;
  logic [SW-1:0] op_tmo;
  logic [IW-1:0] spawn_id;
  logic [SW-1:0] cur_step;
  logic          mem_differs;
  logic [IW-1:0] active_id;
  logic          active_valid;
  logic [AW-1:0] act_futex_addr;
  logic [DW-1:0] act_futex_val;
  logic          wake_busy, dir_right, err_empty, err_overflow;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_sched #(.NTHR(NTHR), .ADDR_W(AW), .DATA_W(DW), .STEP_W(SW), .QUANTUM(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .op(op), .op_addr(op_addr),
    .op_val(op_val), .op_tmo(op_tmo), .spawn_id(spawn_id), .cur_step(cur_step),
    .mem_differs(mem_differs), .active_id(active_id), .active_valid(active_valid),
    .act_futex_addr(act_futex_addr), .act_futex_val(act_futex_val),
    .wake_busy(wake_busy), .dir_right(dir_right), .err_empty(err_empty),
    .err_overflow(err_overflow));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stp(input logic [2:0] o, input logic [AW-1:0] a = '0,
                     input logic [DW-1:0] v = '0, input logic [SW-1:0] t = '0,
                     input logic [IW-1:0] sid = '0);
    step_en = 1'b1; op = o; op_addr = a; op_val = v; op_tmo = t; spawn_id = sid;
    @(negedge clk);
    step_en = 1'b0; op = 3'd0;
  endtask

  task automatic setup(input int n);
    rst_n = 1'b0; step_en = 1'b0; op = '0; op_addr = '0; op_val = '0; op_tmo = '0;
    spawn_id = '0; cur_step = '0; mem_differs = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = n - 1; i >= 0; i--) stp(3'd5, '0, '0, '0, IW'(i));
  endtask

  task automatic t_reset;
    setup(0);
    chk("R1", "active_valid", active_valid, 0);
    chk("R1", "dir_right", dir_right, 1);
    chk("R1", "wake_busy", wake_busy, 0);
    chk("R1", "err_empty", err_empty, 0);
    chk("R1", "err_overflow", err_overflow, 0);
  endtask

  task automatic t_rotation;
    int exp_seq [8] = '{1, 2, 3, 3, 2, 1, 0, 0};
    setup(4);
    chk("R2", "spawned active", active_id, 0);
    chk("R2", "spawned addr", act_futex_addr, 16'hFFFF);
    for (int i = 0; i < 8; i++) begin
      stp(3'd1);
      chk("R3", "yield order", active_id, exp_seq[i]);
    end
    chk("R3", "dir restored", dir_right, 1);
  endtask

  task automatic t_quantum;
    setup(4);
    for (int i = 0; i < 3; i++) begin
      stp(3'd0);
      chk("R4", "before quantum", active_id, 0);
    end
    stp(3'd4);
    chk("R4", "forced switch", active_id, 1);
    stp(3'd0);
    chk("R4", "exit ignored on forced step", active_id, 1);
  endtask

  task automatic t_exit;
    setup(2);
    stp(3'd1);
    chk("R9", "after yield", active_id, 1);
    stp(3'd4);
    chk("R9", "marked still active", active_id, 1);
    stp(3'd0);
    chk("R9", "discard and flip", active_id, 0);
    chk("R9", "dir after flip", dir_right, 0);
    stp(3'd4);
    stp(3'd0);
    chk("R9", "last removed", active_valid, 0);
    chk("R10", "no error yet", err_empty, 0);
    stp(3'd0);
    chk("R10", "empty error", err_empty, 1);
    @(negedge clk);
    chk("R10", "empty sticky", err_empty, 1);
  endtask

  task automatic t_futex;
    setup(2);
    stp(3'd2, 16'h0040, 8'd7, 16'd10);
    chk("R5", "wait addr", act_futex_addr, 16'h0040);
    chk("R5", "wait val", act_futex_val, 7);
    chk("R5", "still active", active_id, 0);
    cur_step = 16'd10;
    stp(3'd0);
    chk("R6", "equal timeout switches", active_id, 1);
    stp(3'd1);
    stp(3'd1);
    chk("R6", "back to waiter", active_id, 0);
    cur_step = 16'd11;
    stp(3'd0);
    chk("R6", "timeout wakes stays", active_id, 0);
    chk("R6", "addr cleared", act_futex_addr, 16'hFFFF);
    chk("R6", "val cleared", act_futex_val, 0);
    stp(3'd2, 16'h0050, 8'd3, 16'd100);
    cur_step = 16'd12; mem_differs = 1'b1;
    stp(3'd0);
    mem_differs = 1'b0;
    chk("R6", "mem change wakes", active_id, 0);
    chk("R6", "mem change clears", act_futex_addr, 16'hFFFF);
  endtask

  task automatic t_scan_match;
    setup(4);
    stp(3'd1); stp(3'd1);
    chk("R8", "at thread 2", active_id, 2);
    stp(3'd2, 16'h0055, 8'd1, 16'hFFF0);
    cur_step = 16'd1;
    stp(3'd0);
    chk("R8", "waiter parked", active_id, 3);
    stp(3'd3, 16'h0055);
    chk("R7", "busy", wake_busy, 1);
    chk("R7", "dir left", dir_right, 0);
    chk("R7", "active after wake", active_id, 3);
    stp(3'd0);
    chk("R8", "mismatch moves on", active_id, 2);
    chk("R8", "still busy", wake_busy, 1);
    stp(3'd0);
    chk("R8", "match ends scan", wake_busy, 0);
    chk("R8", "match stays active", active_id, 2);
    chk("R8", "futex kept", act_futex_addr, 16'h0055);
  endtask

  task automatic t_scan_miss;
    setup(2);
    stp(3'd3, 16'h0077);
    chk("R7", "busy", wake_busy, 1);
    chk("R7", "left taken", dir_right, 0);
    chk("R7", "active", active_id, 0);
    stp(3'd0);
    chk("R8", "scan 1", active_id, 0);
    chk("R8", "scan 1 busy", wake_busy, 1);
    stp(3'd0);
    chk("R8", "scan 2", active_id, 1);
    chk("R8", "scan 2 busy", wake_busy, 1);
    stp(3'd0);
    chk("R8", "right empty ends", wake_busy, 0);
    chk("R8", "final active", active_id, 1);
  endtask

  task automatic t_overflow;
    setup(4);
    chk("R11", "no overflow yet", err_overflow, 0);
    stp(3'd5, '0, '0, '0, 2'd2);
    chk("R11", "overflow flag", err_overflow, 1);
    chk("R11", "push dropped", active_id, 0);
    @(negedge clk);
    chk("R11", "overflow sticky", err_overflow, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rotation();
    t_quantum();
    t_exit();
    t_futex();
    t_scan_match();
    t_scan_miss();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule